// File: doc/BRIEF.md
# Three-Slot Compressed Instruction Dispatcher

This block sits between a synchronous instruction memory and the decode stage of a two-issue processor whose program image carries no padding NOPs. Every fetch returns one 64-bit word holding two 32-bit instructions. The words are dropped into a three-entry slot bank that never shifts: a 3-bit occupancy mask and a rotating read index in the range 0 to 2 decide which slots are written and which are read. Bit 0 of each instruction says whether it issues together with the instruction that follows it.

Each issue produces a registered two-lane packet: the left lane feeds the multiply-accumulate unit and the right lane feeds the memory unit. A lane with nothing to carry receives the all-zero NOP. The block drives the fetch address and a fetch strobe, holds its packet under back-pressure from decode, and restarts from a redirect address on a flush.

Top module: `cdisp_top`

## Requirements
- R1: After reset all slots are empty, the read index is 0, `pkt_valid_o` is 0, `fetch_addr_o` equals RESET_ADDR and `fetch_en_o` is 1.
- R2: A fetched word's bits 31:0 are the earlier instruction and bits 63:32 the later one. They are written into two empty slots in cyclic order (0, 1, 2, 0, ...) directly after the occupied slot, or into slots 0 and 1 when the bank is empty. The write position depends only on the occupancy mask.
- R3: `fetch_en_o` is 1 only when at least two slots are empty and there is no stall and no flush. The fetch data is taken in that cycle, and `fetch_addr_o` then increases by 1. Otherwise the address and the slot contents are held.
- R4: An instruction with bit 0 set issues together with the next instruction in sequence. The earlier instruction goes to `mac_instr_o` and the later one to `mem_instr_o`. The pair waits until both are in the bank.
- R5: A lone instruction (bit 0 clear) whose bits 31:30 are 2'b11 goes to `mem_instr_o`, with `mac_instr_o` = 0. Any other lone instruction goes to `mac_instr_o`, with `mem_instr_o` = 0. An all-zero instruction issues as a packet of two zero lanes.
- R6: After an issue the read index becomes (index + 1 + p) mod 3, where p is bit 0 of the first issued instruction. Whenever the bank becomes empty the index is 0.
- R7: The occupancy mask that follows a cycle with an issue is never 3'b111.
- R8: While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, the packet, the occupancy and the index hold, and no fetch occurs. No instruction is lost or repeated across the stall.
- R9: A flush empties the bank, resets the index to 0 and drops the packet. In the next cycle `fetch_addr_o` equals the redirect address and a fetch is requested.
- R10: With `pkt_ready_i` held at 1 and a stream of lone instructions, one packet issues every cycle and fetches occur on alternate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the bank and redirect fetch |
| redirect_addr_i | input | AW | Fetch word address loaded on flush |
| fetch_en_o | output | 1 | Fetch strobe; data is taken this cycle |
| fetch_addr_o | output | AW | Word address of the 64-bit fetch |
| fetch_data_i | input | 2*ILEN | Fetched word, valid while fetch_en_o is 1 |
| pkt_valid_o | output | 1 | Packet on the lanes is valid |
| pkt_ready_i | input | 1 | Decode accepts the packet |
| mac_instr_o | output | ILEN | Left (MAC) lane instruction |
| mem_instr_o | output | ILEN | Right (MEM) lane instruction |

## Verification
The bench goes after four corner cases.

- **Pair split across fetch words.** The first half of a pair is the last instruction of one word. A design that did not wait for the partner would issue a wrong pair, and a design that advanced the index by the wrong amount would skip or repeat instructions.
- **Memory-class lone instructions and NOP words.** A wrong lane choice would place a memory-class instruction on the MAC side.
- **A long decode stall.** A design that kept fetching or issuing during the stall would drop words or change the packet under the consumer.
- **A flush in mid-stream.** A design that left the index or occupancy stale would resume at the wrong slot instead of at slot 0 of the redirected stream.

The bench also counts packets and fetch strobes in a steady run of lone instructions. A design that fetched with only one slot free would overwrite a live slot. A design that stalled needlessly would miss the one-per-cycle rate.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;
  localparam int unsigned NSLOT = 3;
  typedef logic [1:0] sidx_t;

  function automatic sidx_t sidx_inc(input sidx_t a);
    return (a == 2'd2) ? 2'd0 : a + 2'd1;
  endfunction

  function automatic logic [NSLOT-1:0] sidx_bit(input sidx_t a);
    case (a)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      2'd2:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/cdisp_fetch_ctl.sv
module cdisp_fetch_ctl #(
  parameter int unsigned   AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] redirect_addr_i,
  input  logic          room_i,
  input  logic          stall_i,
  output logic          fetch_en_o,
  output logic [AW-1:0] fetch_addr_o
);
  logic [AW-1:0] addr_q;

  assign fetch_en_o   = room_i && !stall_i && !flush_i;
  assign fetch_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= RESET_ADDR;
    else if (flush_i)    addr_q <= redirect_addr_i;
    else if (fetch_en_o) addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/cdisp_slot_bank.sv
module cdisp_slot_bank
  import cdisp_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       wr_en_i,
  input  logic [2*ILEN-1:0]          wr_word_i,
  input  logic                       issue_en_i,
  input  logic                       issue_two_i,
  output logic [NSLOT-1:0]           valid_o,
  output sidx_t                      idx_o,
  output logic [NSLOT-1:0][ILEN-1:0] slot_o
);
  logic [NSLOT-1:0] valid_q, valid_d, wr_mask, rd_mask;
  sidx_t            idx_q, idx_d, wr_base, wr_next, idx_nx1;

  // fill only happens with at most one occupied slot; write after it
  always_comb begin
    case (valid_q)
      3'b001:  wr_base = 2'd1;
      3'b010:  wr_base = 2'd2;
      default: wr_base = 2'd0;
    endcase
  end

  assign wr_next = sidx_inc(wr_base);
  assign idx_nx1 = sidx_inc(idx_q);
  assign wr_mask = wr_en_i ? (sidx_bit(wr_base) | sidx_bit(wr_next)) : '0;
  assign rd_mask = issue_en_i ?
                   (sidx_bit(idx_q) | (issue_two_i ? sidx_bit(idx_nx1) : '0)) : '0;

  always_comb begin
    valid_d = flush_i ? '0 : ((valid_q & ~rd_mask) | wr_mask);
    if (flush_i || valid_d == '0) idx_d = '0;
    else if (issue_en_i)          idx_d = issue_two_i ? sidx_inc(idx_nx1) : idx_nx1;
    else                          idx_d = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [ILEN-1:0] data_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q <= '0;
      else if (wr_mask[g])
        data_q <= (wr_base == sidx_t'(g)) ? wr_word_i[ILEN-1:0] : wr_word_i[2*ILEN-1:ILEN];
    end
    assign slot_o[g] = data_q;
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/cdisp_issue_sel.sv
module cdisp_issue_sel
  import cdisp_pkg::*;
#(
  parameter int unsigned ILEN      = 32,
  parameter logic [1:0]  MEM_CLASS = 2'b11
) (
  input  logic [NSLOT-1:0][ILEN-1:0] slot_i,
  input  logic [NSLOT-1:0]           valid_i,
  input  sidx_t                      idx_i,
  output logic                       head_ok_o,
  output logic                       two_o,
  output logic [ILEN-1:0]            mac_o,
  output logic [ILEN-1:0]            mem_o
);
  function automatic logic [ILEN-1:0] pick(input logic [NSLOT-1:0][ILEN-1:0] s, input sidx_t i);
    case (i)
      2'd0:    return s[0];
      2'd1:    return s[1];
      2'd2:    return s[2];
      default: return '0;
    endcase
  endfunction

  sidx_t           tail_idx;
  logic [ILEN-1:0] head, tail;
  logic            head_v, tail_v, is_mem;

  assign tail_idx  = sidx_inc(idx_i);
  assign head      = pick(slot_i, idx_i);
  assign tail      = pick(slot_i, tail_idx);
  assign head_v    = |(valid_i & sidx_bit(idx_i));
  assign tail_v    = |(valid_i & sidx_bit(tail_idx));
  assign two_o     = head[0];
  assign head_ok_o = head_v && (!head[0] || tail_v);
  assign is_mem    = (head[ILEN-1 -: 2] == MEM_CLASS);

  always_comb begin
    if (head[0]) begin
      mac_o = head;
      mem_o = tail;
    end else if (is_mem) begin
      mac_o = '0;
      mem_o = head;
    end else begin
      mac_o = head;
      mem_o = '0;
    end
  end
endmodule

// File: rtl/cdisp_top.sv
module cdisp_top
  import cdisp_pkg::*;
#(
  parameter int unsigned   ILEN       = 32,
  parameter int unsigned   AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  parameter logic [1:0]    MEM_CLASS  = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [AW-1:0]     redirect_addr_i,
  output logic              fetch_en_o,
  output logic [AW-1:0]     fetch_addr_o,
  input  logic [2*ILEN-1:0] fetch_data_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [ILEN-1:0]   mac_instr_o,
  output logic [ILEN-1:0]   mem_instr_o
);
  logic [NSLOT-1:0]           slot_valid;
  sidx_t                      rd_idx;
  logic [NSLOT-1:0][ILEN-1:0] slots;
  logic                       head_ok, head_two, stall, issue_fire, room;
  logic [ILEN-1:0]            mac_d, mem_d, mac_q, mem_q;
  logic                       pkt_valid_q;

  assign stall      = pkt_valid_q && !pkt_ready_i;
  assign issue_fire = head_ok && !stall && !flush_i;
  assign room       = ($countones(slot_valid) <= 1);

  cdisp_fetch_ctl #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .flush_i         (flush_i),
    .redirect_addr_i (redirect_addr_i),
    .room_i          (room),
    .stall_i         (stall),
    .fetch_en_o      (fetch_en_o),
    .fetch_addr_o    (fetch_addr_o)
  );

  cdisp_slot_bank #(.ILEN(ILEN)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .wr_en_i     (fetch_en_o),
    .wr_word_i   (fetch_data_i),
    .issue_en_i  (issue_fire),
    .issue_two_i (head_two),
    .valid_o     (slot_valid),
    .idx_o       (rd_idx),
    .slot_o      (slots)
  );

  cdisp_issue_sel #(.ILEN(ILEN), .MEM_CLASS(MEM_CLASS)) u_sel (
    .slot_i    (slots),
    .valid_i   (slot_valid),
    .idx_i     (rd_idx),
    .head_ok_o (head_ok),
    .two_o     (head_two),
    .mac_o     (mac_d),
    .mem_o     (mem_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_valid_q <= 1'b0;
      mac_q       <= '0;
      mem_q       <= '0;
    end else if (flush_i) begin
      pkt_valid_q <= 1'b0;
    end else if (issue_fire) begin
      pkt_valid_q <= 1'b1;
      mac_q       <= mac_d;
      mem_q       <= mem_d;
    end else if (pkt_ready_i) begin
      pkt_valid_q <= 1'b0;
    end
  end

  assign pkt_valid_o = pkt_valid_q;
  assign mac_instr_o = mac_q;
  assign mem_instr_o = mem_q;
endmodule

// File: rtl/cdisp_chk.sv
module cdisp_chk
  import cdisp_pkg::*;
#(
  parameter int unsigned ILEN = 32,
  parameter int unsigned AW   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             pkt_ready_i,
  input logic             pkt_valid_o,
  input logic [ILEN-1:0]  mac_instr_o,
  input logic [ILEN-1:0]  mem_instr_o,
  input logic             fetch_en_o,
  input logic [AW-1:0]    fetch_addr_o,
  input logic [NSLOT-1:0] slot_valid,
  input sidx_t            rd_idx,
  input logic             issue_fire
);
  AST_NOT_FULL_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_fire |=> slot_valid != 3'b111); // R7
  AST_EMPTY_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid == '0 |-> rd_idx == 2'd0); // R6
  AST_IDX_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx != 2'd3); // R6
  AST_FETCH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |-> $countones(slot_valid) <= 1); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_en_o && !flush_i) |=> $stable(fetch_addr_o)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i && !flush_i) |=>
      (pkt_valid_o && $stable(mac_instr_o) && $stable(mem_instr_o)
       && $stable(slot_valid) && $stable(rd_idx))); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (slot_valid == '0 && !pkt_valid_o)); // R9
endmodule

bind cdisp_top cdisp_chk #(.ILEN(ILEN), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .pkt_ready_i  (pkt_ready_i),
  .pkt_valid_o  (pkt_valid_o),
  .mac_instr_o  (mac_instr_o),
  .mem_instr_o  (mem_instr_o),
  .fetch_en_o   (fetch_en_o),
  .fetch_addr_o (fetch_addr_o),
  .slot_valid   (slot_valid),
  .rd_idx       (rd_idx),
  .issue_fire   (issue_fire)
);

// File: tb/sim_cdisp_top.sv
`timescale 1ns/1ps
module sim_cdisp_top;
  localparam int ILEN = 32;
  localparam int AW   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic [AW-1:0]     redir = '0;
  logic              fetch_en;
  logic [AW-1:0]     fetch_addr;
  logic [2*ILEN-1:0] fetch_data;
  logic              pkt_valid;
  logic              ready = 1'b1;
  logic [ILEN-1:0]   mac, mem;

  logic [31:0] ins [0:63];
  logic [63:0] imem [0:31];
  int          total = 0;
  int          bad = 0;
  logic        sb_on = 1'b0;
  logic [5:0]  sb_ptr = '0;

  always #5 clk = ~clk;

  assign fetch_data = imem[fetch_addr[4:0]];

  cdisp_top #(.ILEN(ILEN), .AW(AW)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .flush_i (flush), .redirect_addr_i (redir),
    .fetch_en_o (fetch_en), .fetch_addr_o (fetch_addr), .fetch_data_i (fetch_data),
    .pkt_valid_o (pkt_valid), .pkt_ready_i (ready),
    .mac_instr_o (mac), .mem_instr_o (mem)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] cls, input logic [20:0] id, input logic p);
    return {cls, 8'h5A, id, p};
  endfunction

  task automatic load_mem();
    for (int a = 0; a < 32; a++) imem[a] = {ins[2*a+1], ins[2*a]};
  endtask

  task automatic fill_singles();
    for (int i = 0; i < 64; i++) ins[i] = mk(2'(i % 4), 21'(i + 1), 1'b0);
  endtask

  task automatic do_reset();
    sb_on = 1'b0;
    rst_n = 1'b0;
    flush = 1'b0;
    ready = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    sb_ptr = '0;
    sb_on = 1'b1;
  endtask

  // scoreboard: sequence model of issue order and lane choice (R4, R5, R6)
  always @(negedge clk) begin
    if (sb_on && rst_n && pkt_valid && ready) begin
      logic [31:0] a, b, em, ee;
      a = ins[sb_ptr];
      b = ins[sb_ptr + 6'd1];
      if (a[0]) begin em = a; ee = b; sb_ptr = sb_ptr + 6'd2; end
      else if (a[31:30] == 2'b11) begin em = '0; ee = a; sb_ptr = sb_ptr + 6'd1; end
      else begin em = a; ee = '0; sb_ptr = sb_ptr + 6'd1; end
      chk(mac == em && mem == ee, "R4 R5 R6 packet order/lanes", {mac, mem}, {em, ee});
    end
  end

  task automatic t_reset();
    fill_singles();
    load_mem();
    do_reset();
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 pkt_valid after reset", 64'(pkt_valid), 64'd0);
    chk(fetch_addr == '0, "R1 fetch_addr after reset", 64'(fetch_addr), 64'd0);
    chk(fetch_en == 1'b1, "R1 fetch_en after reset", 64'(fetch_en), 64'd1);
  endtask

  task automatic t_singles_rate();
    int hs, fe, prev_fe, twice;
    logic [AW-1:0] a0;
    fill_singles();
    ins[9] = 32'h0;  // zero instruction as a lone NOP
    load_mem();
    do_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    a0 = fetch_addr;
    hs = 0; fe = 0; prev_fe = 0; twice = 0;
    for (int c = 0; c < 12; c++) begin
      if (pkt_valid && ready) hs++;
      if (fetch_en) begin
        fe++;
        if (prev_fe != 0) twice++;
      end
      prev_fe = int'(fetch_en);
      @(negedge clk);
    end
    chk(hs == 12, "R10 one lone packet per cycle", 64'(hs), 64'd12);
    chk(fe == 6, "R10 fetch on alternate cycles", 64'(fe), 64'd6);
    chk(twice == 0, "R3 no fetch with one free slot", 64'(twice), 64'd0);
    chk(fetch_addr == a0 + AW'(fe), "R3 address step per fetch", 64'(fetch_addr), 64'(a0 + AW'(fe)));
    repeat (10) @(negedge clk);
  endtask

  task automatic t_pairs();
    fill_singles();
    ins[0]  = mk(2'b00, 21'd100, 1'b0);
    ins[1]  = mk(2'b01, 21'd101, 1'b1);  // pair split across words R2 R4
    ins[2]  = mk(2'b11, 21'd102, 1'b0);
    ins[3]  = mk(2'b11, 21'd103, 1'b0);
    ins[4]  = mk(2'b11, 21'd104, 1'b1);
    ins[5]  = mk(2'b00, 21'd105, 1'b0);
    ins[6]  = mk(2'b10, 21'd106, 1'b1);
    ins[7]  = mk(2'b11, 21'd107, 1'b0);
    ins[8]  = 32'h0;
    ins[9]  = mk(2'b00, 21'd109, 1'b1);
    ins[10] = mk(2'b00, 21'd110, 1'b0);
    ins[11] = mk(2'b01, 21'd111, 1'b1);
    ins[12] = mk(2'b10, 21'd112, 1'b0);
    ins[13] = mk(2'b11, 21'd113, 1'b1);
    ins[14] = mk(2'b11, 21'd114, 1'b0);
    load_mem();
    do_reset();
    repeat (30) @(negedge clk);
    chk(sb_ptr >= 6'd20, "R4 pairs keep flowing", 64'(sb_ptr), 64'd20);
  endtask

  task automatic t_stall();
    logic [31:0] hm, he;
    logic [AW-1:0] ha;
    logic [5:0] p0;
    int ok;
    fill_singles();
    ins[20] = mk(2'b00, 21'd220, 1'b1);
    load_mem();
    do_reset();
    repeat (6) @(posedge clk);
    #2 ready = 1'b0;
    @(negedge clk);
    hm = mac; he = mem; ha = fetch_addr; p0 = sb_ptr;
    ok = 1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (!pkt_valid || mac != hm || mem != he || fetch_en || fetch_addr != ha) ok = 0;
    end
    chk(ok == 1, "R8 packet and fetch held in stall", 64'(ok), 64'd1);
    @(posedge clk);
    #2 ready = 1'b1;
    repeat (16) @(negedge clk);
    chk(sb_ptr > p0 + 6'd10, "R8 stream resumes after stall", 64'(sb_ptr), 64'(p0 + 6'd11));
  endtask

  task automatic t_flush();
    fill_singles();
    ins[32] = mk(2'b11, 21'd332, 1'b0);
    ins[33] = mk(2'b01, 21'd333, 1'b1);
    ins[34] = mk(2'b00, 21'd334, 1'b0);
    load_mem();
    do_reset();
    repeat (7) @(posedge clk);
    #2 ready = 1'b0;
    @(posedge clk);
    #2 flush = 1'b1;
    redir = AW'(16);
    sb_ptr = 6'd32;
    @(posedge clk);
    #2 flush = 1'b0;
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R9 packet dropped on flush", 64'(pkt_valid), 64'd0);
    chk(fetch_addr == AW'(16), "R9 redirect address", 64'(fetch_addr), 64'd16);
    chk(fetch_en == 1'b1, "R9 fetch after flush", 64'(fetch_en), 64'd1);
    @(posedge clk);
    #2 ready = 1'b1;
    repeat (12) @(negedge clk);
    chk(sb_ptr > 6'd40, "R6 restart at slot0 of new stream", 64'(sb_ptr), 64'd41);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_singles_rate();
    t_pairs();
    t_stall();
    t_flush();
    sb_on = 1'b0;
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule